// File: doc/BRIEF.md
# Frame Header Splitter

The block receives complete layer-2 frames as a byte-lane stream with valid/ready handshaking, byte-keep, last and user sideband. It splits each frame into two outputs.

The first output is a parallel header record with its own valid/ready handshake. It holds the 48-bit destination address, the 48-bit source address and the 16-bit type field. The second output is a stream that carries only the bytes after the 14-byte header. These bytes are moved down so that the first payload byte sits in byte lane 0. A payload may therefore straddle input beats.

The bus width is a parameter from 8 to 512 bits. Byte-keep is honoured only when the width exceeds 8 bits. The user bit on the final input beat marks a bad frame and is passed on to the final payload beat. Frames too short to carry a header and at least one payload byte are discarded, and a one-cycle pulse reports each one. A typical user is a receive path that wants header fields in registers and a clean payload stream for the next protocol stage.

Top module: `frame_hdr_split`

## Requirements
- R1: Frame bytes 0..5 form `hdrDest`, bytes 6..11 form `hdrSrc` and bytes 12..13 form `hdrType`. In each field the earliest byte is the most significant byte.
- R2: Once `hdrValid` rises, it and all three header fields hold steady until a cycle in which `hdrReady` is high.
- R3: The payload stream carries exactly the frame bytes from byte 14 onward, in order, starting in lane 0. Byte lane i is `payData[8i+7:8i]` and is marked by `payKeep[i]`. Keep is contiguous from lane 0. Keep is all ones on every beat except the last. `payLast` is high only on the beat holding the final byte.
- R4: At the default 32-bit width, when the last input beat has lane 2 valid, its bytes from lane 2 upward do not fit into the realigned beat. The block then emits them as one extra final beat, with `sReady` low for that cycle.
- R5: Idle cycles on the input and stalls on either output never lose, duplicate or reorder header records or payload bytes.
- R6: While a header record is waiting for `hdrReady`, the first beat of the next frame is not accepted (`sReady` low).
- R7: A frame shorter than 15 bytes produces no header record and no payload beats. `frameDropped` is high for exactly one cycle for each such frame.
- R8: `payUser` on the final payload beat equals `sUser` on the final input beat of that frame. On all other payload beats `payUser` is 0.
- R9: During and right after a synchronous active-high reset, `hdrValid`, `payValid` and `frameDropped` are low and `sReady` is high. The next beat accepted after reset starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sData | input | DATA_W | Input frame bytes, lane 0 first |
| sKeep | input | DATA_W/8 | Input byte-lane valid flags |
| sValid | input | 1 | Input beat valid |
| sReady | output | 1 | Input beat accepted when high with sValid |
| sLast | input | 1 | Final beat of the input frame |
| sUser | input | 1 | Bad-frame flag, sampled on the final beat |
| hdrValid | output | 1 | Header record valid |
| hdrReady | input | 1 | Header record consumed |
| hdrDest | output | 48 | Destination address |
| hdrSrc | output | 48 | Source address |
| hdrType | output | 16 | Type field |
| payData | output | DATA_W | Realigned payload bytes |
| payKeep | output | DATA_W/8 | Payload byte-lane valid flags |
| payValid | output | 1 | Payload beat valid |
| payReady | input | 1 | Payload beat consumed |
| payLast | output | 1 | Final payload beat |
| payUser | output | 1 | Bad-frame flag on the final payload beat |
| frameDropped | output | 1 | One-cycle pulse per discarded short frame |

## Verification
The assertions rely on an upstream that behaves as a stream source should. A beat that is offered holds steady until accepted. Keep runs contiguous from lane 0, is full on every beat except the last, and is never zero. The stimulus builds every frame from a byte list that obeys these rules. It holds a beat in place whenever `sReady` is low and only uses the idle pattern to delay new beats, never to withdraw an offered one. The stall patterns on `hdrReady` and `payReady` are free to drop ready at any cycle, since nothing is assumed about the consumers.

// File: rtl/frame_hdr_split_pkg.sv
package frame_hdr_split_pkg;

  localparam int HDR_LEN = 14;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_BODY = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capHdr;    // write header bytes of the current beat
    logic pubHdr;    // header complete, raise hdrValid
    logic loadCarry; // keep current beat for realignment
    logic tailSel;   // output the carried bytes alone
  } strobe_t;

endpackage

// File: rtl/frame_hdr_split_ctrl.sv
module frame_hdr_split_ctrl
  import frame_hdr_split_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic                  inLast,
  input  logic                  inUser,
  input  logic [DATA_W/8-1:0]   inKeep,
  input  logic                  hdrValid,
  input  logic                  payReady,
  output logic                  inReady,
  output logic                  payValid,
  output logic                  payLast,
  output logic                  payUser,
  output logic                  dropPulse,
  output strobe_t               strb,
  output logic [((((HDR_LEN+DATA_W/8-1)/(DATA_W/8)) > 1) ? $clog2((HDR_LEN+DATA_W/8-1)/(DATA_W/8)) : 1)-1:0] beatIdx
);

  localparam int BYTES     = DATA_W / 8;
  localparam int HDR_BEATS = (HDR_LEN + BYTES - 1) / BYTES;
  localparam int SH        = HDR_LEN - (HDR_BEATS - 1) * BYTES;
  localparam int BW        = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

  phase_t        phase, phaseNxt;
  logic [BW-1:0] beatCnt, beatNxt;
  logic          userHold, userNxt;
  logic          dropNxt;
  logic [BYTES:0] keepPad;
  logic          spill;
  logic          lastHdrBeat;

  assign keepPad     = {1'b0, inKeep};
  assign spill       = keepPad[SH];
  assign lastHdrBeat = (beatCnt == BW'(HDR_BEATS - 1));
  assign beatIdx     = beatCnt;

  always_comb begin
    phaseNxt = phase;
    beatNxt  = beatCnt;
    userNxt  = userHold;
    dropNxt  = 1'b0;
    strb     = '0;
    inReady  = 1'b0;
    payValid = 1'b0;
    payLast  = 1'b0;
    payUser  = 1'b0;
    case (phase)
      PH_HDR: begin
        inReady = !hdrValid;
        if (inValid && !hdrValid) begin
          strb.capHdr = 1'b1;
          if (lastHdrBeat) begin
            strb.loadCarry = 1'b1;
            beatNxt        = '0;
            if (!inLast) begin
              strb.pubHdr = 1'b1;
              phaseNxt    = PH_BODY;
            end else if (spill) begin
              strb.pubHdr = 1'b1;
              phaseNxt    = PH_TAIL;
              userNxt     = inUser;
            end else begin
              dropNxt = 1'b1;
            end
          end else if (inLast) begin
            beatNxt = '0;
            dropNxt = 1'b1;
          end else begin
            beatNxt = beatCnt + 1'b1;
          end
        end
      end
      PH_BODY: begin
        inReady  = payReady;
        payValid = inValid;
        payLast  = inLast && !spill;
        payUser  = inLast && !spill && inUser;
        if (inValid && payReady) begin
          strb.loadCarry = 1'b1;
          if (inLast) begin
            if (spill) begin
              phaseNxt = PH_TAIL;
              userNxt  = inUser;
            end else begin
              phaseNxt = PH_HDR;
            end
          end
        end
      end
      PH_TAIL: begin
        payValid     = 1'b1;
        payLast      = 1'b1;
        payUser      = userHold;
        strb.tailSel = 1'b1;
        if (payReady) phaseNxt = PH_HDR;
      end
      default: phaseNxt = PH_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HDR;
      beatCnt   <= '0;
      userHold  <= 1'b0;
      dropPulse <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      beatCnt   <= beatNxt;
      userHold  <= userNxt;
      dropPulse <= dropNxt;
    end
  end

  // the carried tail beat is the only output; input must wait
  assert_tail_blocks_input_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TAIL) |-> (!inReady && payValid && payLast))
    else $error("tail beat did not block input");

  // a pending header record gates the start of the next frame
  assert_hold_next_frame_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HDR && hdrValid) |-> !inReady)
    else $error("next frame accepted while header pending");

  // a dropped frame leaves the payload side quiet
  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    dropPulse |-> (!payValid && !$past(dropPulse)))
    else $error("drop pulse overlapped payload or stretched");

  // after reset the parser waits at frame start
  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!payValid && !dropPulse && phase == PH_HDR))
    else $error("not idle after reset");

endmodule

// File: rtl/frame_hdr_split_dp.sv
module frame_hdr_split_dp
  import frame_hdr_split_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  logic [((((HDR_LEN+DATA_W/8-1)/(DATA_W/8)) > 1) ? $clog2((HDR_LEN+DATA_W/8-1)/(DATA_W/8)) : 1)-1:0] beatIdx,
  input  logic [DATA_W-1:0]   inData,
  input  logic [DATA_W/8-1:0] inKeep,
  input  logic                hdrReady,
  input  logic                payValid,
  output logic                hdrValid,
  output logic [47:0]         hdrDest,
  output logic [47:0]         hdrSrc,
  output logic [15:0]         hdrType,
  output logic [DATA_W-1:0]   payData,
  output logic [DATA_W/8-1:0] payKeep
);

  localparam int BYTES     = DATA_W / 8;
  localparam int HDR_BEATS = (HDR_LEN + BYTES - 1) / BYTES;
  localparam int SH        = HDR_LEN - (HDR_BEATS - 1) * BYTES;
  localparam int LOW_N     = BYTES - SH;   // output lanes fed by the carry

  logic [HDR_LEN*8-1:0] hdrBits;
  logic [DATA_W-1:0]    carryData;
  logic [BYTES-1:0]     carryKeep;
  logic [DATA_W-1:0]    bodyData, tailData;
  logic [BYTES-1:0]     bodyKeep, tailKeep;

  // header byte b lands at the top of the record for b == 0
  always_ff @(posedge clk) begin
    if (strb.capHdr) begin
      for (int b = 0; b < HDR_LEN; b++) begin
        if ((b / BYTES) == int'(beatIdx))
          hdrBits[(HDR_LEN-1-b)*8 +: 8] <= inData[(b % BYTES)*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                hdrValid <= 1'b0;
    else if (strb.pubHdr)   hdrValid <= 1'b1;
    else if (hdrReady)      hdrValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carryData <= '0;
      carryKeep <= '0;
    end else if (strb.loadCarry) begin
      carryData <= inData;
      carryKeep <= inKeep;
    end
  end

  assign hdrDest = hdrBits[111:64];
  assign hdrSrc  = hdrBits[63:16];
  assign hdrType = hdrBits[15:0];

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    if (j < LOW_N) begin : g_from_carry
      assign bodyData[j*8 +: 8] = carryData[(j+SH)*8 +: 8];
      assign bodyKeep[j]        = carryKeep[j+SH];
      assign tailData[j*8 +: 8] = carryData[(j+SH)*8 +: 8];
      assign tailKeep[j]        = carryKeep[j+SH];
    end else begin : g_from_input
      assign bodyData[j*8 +: 8] = inData[(j-LOW_N)*8 +: 8];
      assign bodyKeep[j]        = inKeep[j-LOW_N];
      assign tailData[j*8 +: 8] = 8'h00;
      assign tailKeep[j]        = 1'b0;
    end
  end

  assign payData = strb.tailSel ? tailData : bodyData;
  assign payKeep = strb.tailSel ? tailKeep : bodyKeep;

  // header record frozen until consumed
  assert_hdr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (hdrValid && !hdrReady) |=> (hdrValid && $stable(hdrBits)))
    else $error("header changed while waiting");

  // no header byte may be overwritten while a record is pending
  assert_no_capture_pending_R6: assert property (@(posedge clk) disable iff (rst)
    strb.capHdr |-> !hdrValid)
    else $error("header captured over pending record");

  // every payload beat starts in lane 0
  assert_keep_lane0_R3: assert property (@(posedge clk) disable iff (rst)
    payValid |-> payKeep[0])
    else $error("payload beat without lane 0");

  assert_reset_hdr_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hdrValid)
    else $error("header valid after reset");

endmodule

// File: rtl/frame_hdr_split.sv
module frame_hdr_split
  import frame_hdr_split_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   sData,
  input  logic [DATA_W/8-1:0] sKeep,
  input  logic                sValid,
  output logic                sReady,
  input  logic                sLast,
  input  logic                sUser,
  output logic                hdrValid,
  input  logic                hdrReady,
  output logic [47:0]         hdrDest,
  output logic [47:0]         hdrSrc,
  output logic [15:0]         hdrType,
  output logic [DATA_W-1:0]   payData,
  output logic [DATA_W/8-1:0] payKeep,
  output logic                payValid,
  input  logic                payReady,
  output logic                payLast,
  output logic                payUser,
  output logic                frameDropped
);

  localparam int  BYTES     = DATA_W / 8;
  localparam bit  KEEP_EN   = (DATA_W > 8);
  localparam int  HDR_BEATS = (HDR_LEN + BYTES - 1) / BYTES;
  localparam int  BW        = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

  strobe_t          strb;
  logic [BW-1:0]    beatIdx;
  logic [BYTES-1:0] keepEff;
  logic [BYTES-1:0] dpKeep;

  if (KEEP_EN) begin : g_keep
    assign keepEff = sKeep;
    assign payKeep = dpKeep;
  end else begin : g_nokeep
    assign keepEff = '1;
    assign payKeep = '1;
  end

  frame_hdr_split_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (sValid),
    .inLast   (sLast),
    .inUser   (sUser),
    .inKeep   (keepEff),
    .hdrValid (hdrValid),
    .payReady (payReady),
    .inReady  (sReady),
    .payValid (payValid),
    .payLast  (payLast),
    .payUser  (payUser),
    .dropPulse(frameDropped),
    .strb     (strb),
    .beatIdx  (beatIdx)
  );

  frame_hdr_split_dp #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .beatIdx (beatIdx),
    .inData  (sData),
    .inKeep  (keepEff),
    .hdrReady(hdrReady),
    .payValid(payValid),
    .hdrValid(hdrValid),
    .hdrDest (hdrDest),
    .hdrSrc  (hdrSrc),
    .hdrType (hdrType),
    .payData (payData),
    .payKeep (dpKeep)
  );

endmodule

// File: tb/frame_hdr_split_tb_top.sv
module frame_hdr_split_tb_top;

  localparam int DATA_W = 32;
  localparam int BYTES  = DATA_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] sData = '0;
  logic [BYTES-1:0]  sKeep = '0;
  logic sValid = 1'b0, sLast = 1'b0, sUser = 1'b0;
  logic sReady;
  logic hdrValid, hdrReady = 1'b0;
  logic [47:0] hdrDest, hdrSrc;
  logic [15:0] hdrType;
  logic [DATA_W-1:0] payData;
  logic [BYTES-1:0]  payKeep;
  logic payValid, payReady = 1'b0, payLast, payUser, frameDropped;

  always #4 clk = ~clk;  // 125 MHz

  frame_hdr_split #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .sData(sData), .sKeep(sKeep), .sValid(sValid),
    .sReady(sReady), .sLast(sLast), .sUser(sUser), .hdrValid(hdrValid),
    .hdrReady(hdrReady), .hdrDest(hdrDest), .hdrSrc(hdrSrc), .hdrType(hdrType),
    .payData(payData), .payKeep(payKeep), .payValid(payValid),
    .payReady(payReady), .payLast(payLast), .payUser(payUser),
    .frameDropped(frameDropped)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [DATA_W-1:0] qData[$];
  logic [BYTES-1:0]  qKeep[$];
  bit                qLast[$];
  bit                qUser[$];
  logic [111:0]      eHdr[$];
  logic [7:0]        ePay[$];
  bit                ePayLast[$];
  bit                ePayUser[$];
  int                expDrops = 0;
  int                seenDrops = 0;

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic addFrame(int len, bit usr, int seed);
    logic [7:0] fb[$];
    int nb;
    for (int i = 0; i < len; i++) fb.push_back(8'((seed * 31 + i * 7 + 3) & 255));
    nb = (len + BYTES - 1) / BYTES;
    for (int k = 0; k < nb; k++) begin
      logic [DATA_W-1:0] d;
      logic [BYTES-1:0]  kp;
      d = '0; kp = '0;
      for (int l = 0; l < BYTES; l++) begin
        if (k * BYTES + l < len) begin
          d[l*8 +: 8] = fb[k * BYTES + l];
          kp[l] = 1'b1;
        end
      end
      qData.push_back(d);
      qKeep.push_back(kp);
      qLast.push_back(k == nb - 1);
      qUser.push_back((k == nb - 1) ? usr : 1'b0);
    end
    if (len >= 15) begin
      logic [111:0] h;
      for (int i = 0; i < 14; i++) h[(13 - i)*8 +: 8] = fb[i];
      eHdr.push_back(h);
      for (int i = 14; i < len; i++) begin
        ePay.push_back(fb[i]);
        ePayLast.push_back(i == len - 1);
        ePayUser.push_back(usr);
      end
    end else begin
      expDrops++;
    end
  endtask

  task automatic doReset();
    sValid = 0; sLast = 0; sUser = 0; hdrReady = 0; payReady = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check(!hdrValid && !payValid && !frameDropped && sReady, "R9", "idle after reset",
          {hdrValid, payValid, frameDropped, sReady}, 4'b0001);
    expDrops = 0; seenDrops = 0;
  endtask

  // runs the queued frames; idle/bp select stall patterns, hdrBlock holds hdrReady low
  task automatic runFrames(string req, bit idle, bit bp, int hdrBlock, int holdBeats);
    int  cyc = 0;
    int  tailCnt = 0;
    bit  firedPrev = 1'b0;
    bit  stallPrev = 1'b0;
    logic [111:0] hdrPrev = '0;
    while (cyc < 60000) begin
      @(negedge clk);
      if (!(sValid && !firedPrev)) begin
        if (qData.size() > 0 && (!idle || (cyc % 4 == 3))) begin
          sData = qData[0]; sKeep = qKeep[0]; sLast = qLast[0]; sUser = qUser[0];
          sValid = 1'b1;
        end else begin
          sValid = 1'b0;
        end
      end
      payReady = bp ? (cyc % 4 == 3) : 1'b1;
      hdrReady = (cyc < hdrBlock) ? 1'b0 : (bp ? ((cyc + 2) % 4 == 3) : 1'b1);
      #1;
      if (frameDropped) seenDrops++;
      if (stallPrev)
        check(hdrValid && {hdrDest, hdrSrc, hdrType} == hdrPrev, "R2", "header held",
              {hdrValid, hdrDest, hdrSrc, hdrType}, {1'b1, hdrPrev});
      stallPrev = hdrValid && !hdrReady;
      hdrPrev   = {hdrDest, hdrSrc, hdrType};
      if (hdrBlock > 0 && cyc == hdrBlock - 1)
        check(hdrValid && sValid && !sReady && qData.size() == holdBeats, "R6",
              "next frame held off", {hdrValid, sValid, sReady, 16'(qData.size())},
              {3'b110, 16'(holdBeats)});
      if (hdrValid && hdrReady) begin
        if (eHdr.size() == 0) check(0, "R1", "unexpected header", {hdrDest, hdrSrc, hdrType}, 0);
        else begin
          check({hdrDest, hdrSrc, hdrType} == eHdr[0], "R1", "header fields",
                {hdrDest, hdrSrc, hdrType}, eHdr[0]);
          void'(eHdr.pop_front());
        end
      end
      if (payValid && payReady) begin
        bit ok = 1'b1;
        bit expLast = 1'b0;
        bit expUser = 1'b0;
        logic [DATA_W-1:0] expData = '0;
        ok = (payKeep != 0) && ((payKeep & (payKeep + 1'b1)) == 0);
        for (int l = 0; l < BYTES; l++) begin
          if (payKeep[l]) begin
            if (ePay.size() == 0) ok = 1'b0;
            else begin
              expData[l*8 +: 8] = ePay[0];
              if (payData[l*8 +: 8] != ePay[0]) ok = 1'b0;
              expLast = ePayLast[0];
              expUser = ePayLast[0] ? ePayUser[0] : 1'b0;
              void'(ePay.pop_front()); void'(ePayLast.pop_front()); void'(ePayUser.pop_front());
            end
          end
        end
        check(ok && payLast == expLast, {req, " R3"}, "payload beat",
              {payLast, payKeep, payData}, {expLast, payKeep, expData});
        check(payUser == expUser, "R8", "payload user", payUser, expUser);
      end
      firedPrev = sValid && sReady;
      if (firedPrev) begin
        void'(qData.pop_front()); void'(qKeep.pop_front());
        void'(qLast.pop_front()); void'(qUser.pop_front());
      end
      cyc++;
      if (qData.size() == 0 && !(sValid && !firedPrev) && eHdr.size() == 0 && ePay.size() == 0) begin
        tailCnt++;
        if (tailCnt > 4) break;
      end
    end
    @(negedge clk);
    sValid = 1'b0;
    check(cyc < 60000 && eHdr.size() == 0 && ePay.size() == 0, req, "all frames delivered",
          {16'(eHdr.size()), 16'(ePay.size())}, 0);
    check(seenDrops == expDrops, "R7", "drop pulses", seenDrops, expDrops);
    seenDrops = 0; expDrops = 0;
  endtask

  task automatic testAlignSweep();  // R1 R3 R4: payload 1..12 bytes, all lane offsets
    for (int n = 1; n <= 12; n++) addFrame(14 + n, 1'b0, n);
    runFrames("R4", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic testStalls();  // R5: idle, backpressure, both
    for (int m = 1; m <= 3; m++) begin
      for (int n = 1; n <= 9; n++) addFrame(14 + n * 3, 1'b0, n + m * 20);
      runFrames("R5", m[0], m[1], 0, 0);
    end
  endtask

  task automatic testRunts();  // R7: short frames vanish between good ones
    addFrame(1, 1'b0, 50);
    addFrame(15, 1'b0, 51);
    addFrame(13, 1'b1, 52);
    addFrame(14, 1'b0, 53);
    addFrame(16, 1'b0, 54);
    addFrame(5, 1'b0, 55);
    runFrames("R7", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic testUser();  // R8: bad-frame flag carried to the last payload beat
    addFrame(15, 1'b1, 60);
    addFrame(17, 1'b0, 61);
    addFrame(40, 1'b1, 62);
    addFrame(41, 1'b1, 63);
    runFrames("R8", 1'b1, 1'b1, 0, 0);
  endtask

  task automatic testLong();  // R3 R5: long payloads under stalls
    addFrame(1514, 1'b0, 70);
    addFrame(314, 1'b1, 71);
    runFrames("R5", 1'b1, 1'b1, 0, 0);
  endtask

  task automatic testHdrHold();  // R6 R2: header stall holds off the next frame
    addFrame(20, 1'b0, 80);
    addFrame(18, 1'b0, 81);
    runFrames("R6", 1'b0, 1'b0, 30, 5);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    testAlignSweep();
    testStalls();
    testRunts();
    testUser();
    testLong();
    testHdrHold();
    doReset();
    addFrame(22, 1'b0, 90);
    runFrames("R9", 1'b0, 1'b0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule